// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block produces a pulse-width modulated output from an 8-bit period timer. The input clock first passes through a selectable prescaler (divide by 1, 4 or 16). Below the timer sits a 2-bit fine count, so one period spans `(period + 1) * 4` fine steps, and each step lasts one prescaled clock. The output is driven high at the start of every period and low once the fine position reaches the active duty value. A duty of zero keeps the output low. A duty longer than the period never clears it.

Software-side logic writes the 10-bit duty through two independent strobes: an 8-bit upper field and a 2-bit lower field. Both fields may be written at any moment. The written value waits in a buffer and is copied into the active duty register only at a period boundary, so a rewrite in the middle of a period cannot cut a pulse short or stretch it. The active duty can be read back, and a one-clock pulse marks the last clock of each period.

A synchronous enable starts the generator. While it is low the output is held low, the counters are held at zero, and the active duty follows the buffer. A synchronous reset clears all state, including the duty buffer.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset, `pwm_out`, `period_end` and `duty_active` are all 0.
- R2: A write with `duty_hi_we` sets duty bits [9:2] to `duty_hi`, and a write with `duty_lo_we` sets duty bits [1:0] to `duty_lo`. Each strobe leaves the other field unchanged, and writes are accepted in any cycle.
- R3: While running, `duty_active` changes only at a period boundary: the clock edge that ends the cycle in which `period_end` is high, or the edge that starts a run. At that edge it takes the buffered duty value held before that edge.
- R4: One period lasts `(period + 1) * 4 * div` input clocks. `period_end` is high for exactly the last clock of each period.
- R5: `presc_sel` selects `div`: 0 selects 1, 1 selects 4, and 2 or 3 selects 16.
- R6: In every period `pwm_out` is high for the first `duty_active * div` clocks and low for the rest.
- R7: With `duty_active` equal to 0, `pwm_out` stays low for the whole period.
- R8: With `duty_active` at or above `(period + 1) * 4`, `pwm_out` stays high for the whole period.
- R9: While `en` is low, `pwm_out` and `period_end` are 0 from the next clock on. The clock edge that first samples `en` high starts a period, with the first clock of that period following that edge.
- R10: Reset clears the duty buffer. After reset, enabling the block without a duty write gives a constant low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| presc_sel | input | 2 | Prescaler select: 0 is /1, 1 is /4, 2 or 3 is /16 |
| period | input | 8 | Last timer value of a period |
| duty_hi_we | input | 1 | Write strobe for the upper duty field |
| duty_hi | input | 8 | Duty bits [9:2] |
| duty_lo_we | input | 1 | Write strobe for the lower duty field |
| duty_lo | input | 2 | Duty bits [1:0] |
| pwm_out | output | 1 | PWM output |
| period_end | output | 1 | High on the last clock of each period |
| duty_active | output | 10 | Active (shadow) duty value |

## Verification
The assertions take for granted that `period` and `presc_sel` stay constant while `en` is high. The timer-range property and the pulse-shape properties depend on that. The stimulus therefore changes these two inputs only after dropping `en` and waiting two clocks. Duty writes are left free, and several land in the middle of a period to exercise the double buffering.

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
  parameter int TW = 8,
  parameter int FW = 2,
  parameter int PW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [1:0]           presc_sel,
  input  logic [TW-1:0]        period,
  input  logic                 duty_hi_we,
  input  logic [TW-1:0]        duty_hi,
  input  logic                 duty_lo_we,
  input  logic [FW-1:0]        duty_lo,
  output logic                 pwm_out,
  output logic                 period_end,
  output logic [TW+FW-1:0]     duty_active
);
  localparam int DW = TW + FW;
  localparam logic [PW-1:0] LAST4  = PW'(3);
  localparam logic [PW-1:0] LAST16 = PW'(15);

  logic [TW-1:0] dh;
  logic [FW-1:0] dl;
  logic [DW-1:0] shadow;
  logic [TW-1:0] tmr;
  logic [FW-1:0] q;
  logic [PW-1:0] pc;
  logic [PW-1:0] last_pc;
  logic          run, out_q;

  always_comb begin
    case (presc_sel)
      2'd0:    last_pc = '0;
      2'd1:    last_pc = LAST4;
      default: last_pc = LAST16;
    endcase
  end

  wire [DW-1:0] buf_val = {dh, dl};
  wire          step    = run && (pc == last_pc);
  wire          qwrap   = step && (q == {FW{1'b1}});
  wire          wrap    = qwrap && (tmr == period);
  wire [DW:0]   nxt_pos = {1'b0, tmr, q} + 1'b1;
  wire          hit     = step && (nxt_pos == {1'b0, shadow});

  always_ff @(posedge clk) begin
    if (rst) begin
      dh <= '0; dl <= '0; shadow <= '0;
      tmr <= '0; q <= '0; pc <= '0;
      run <= 1'b0; out_q <= 1'b0;
    end else begin
      if (duty_hi_we) dh <= duty_hi;
      if (duty_lo_we) dl <= duty_lo;
      if (!en) begin
        run <= 1'b0; out_q <= 1'b0;
        tmr <= '0; q <= '0; pc <= '0;
        shadow <= buf_val;
      end else if (!run || wrap) begin
        run <= 1'b1;
        tmr <= '0; q <= '0; pc <= '0;
        shadow <= buf_val;
        out_q <= (buf_val != '0);
      end else begin
        pc <= step ? '0 : pc + 1'b1;
        if (step)  q   <= q + 1'b1;
        if (qwrap) tmr <= tmr + 1'b1;
        if (hit)   out_q <= 1'b0;
      end
    end
  end

  assign pwm_out     = out_q;
  assign period_end  = wrap;
  assign duty_active = shadow;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    period_end |=> !period_end);
  a_r4_timer_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (tmr <= period));
  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    (period_end && en) |=> (tmr == '0 && q == '0 && pc == '0));
  a_r3_shadow_load: assert property (@(posedge clk) disable iff (rst)
    (period_end && en) |=> (duty_active == $past(buf_val)));
  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    $past(run && en && !period_end) |-> $stable(duty_active));
  a_r6_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> ($past(period_end) || $past(!run && en)));
  a_r6_fall_on_match: assert property (@(posedge clk) disable iff (rst)
    $fell(pwm_out) |-> (!$past(en) || ({tmr, q} == duty_active)));
  a_r9_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_out && !period_end));
endmodule

// File: tb/sim_pwm_dbuf.sv
module sim_pwm_dbuf;
  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic [7:0] period = 8'd9;
  logic duty_hi_we = 1'b0, duty_lo_we = 1'b0;
  logic [7:0] duty_hi = 8'd0;
  logic [1:0] duty_lo = 2'd0;
  logic pwm_out, period_end;
  logic [9:0] duty_active;

  int errs = 0, checks = 0, cycles = 0;
  string phase = "R1";
  bit cmp_on = 0;

  int m_run = 0, m_cnt = 0, m_shadow = 0, m_buf = 0;

  always #5 clk = ~clk;

  pwm_dbuf u0 (.clk, .rst, .en, .presc_sel, .period, .duty_hi_we, .duty_hi,
               .duty_lo_we, .duty_lo, .pwm_out, .period_end, .duty_active);

  function automatic int divof(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;
  endfunction

  function automatic int plen();
    return (int'(period) + 1) * 4 * divof(presc_sel);
  endfunction

  always @(posedge clk) begin
    int nb;
    nb = m_buf;
    if (duty_hi_we) nb = (int'(duty_hi) << 2) | (nb & 3);
    if (duty_lo_we) nb = (nb & 'h3fc) | int'(duty_lo);
    if (rst) begin
      m_run = 0; m_cnt = 0; m_shadow = 0; nb = 0;
    end else if (!en) begin
      m_run = 0; m_cnt = 0; m_shadow = m_buf;
    end else if (m_run == 0 || m_cnt == plen() - 1) begin
      m_run = 1; m_cnt = 0; m_shadow = m_buf;
    end else begin
      m_cnt = m_cnt + 1;
    end
    m_buf = nb;
    cmp_on = 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      check({phase, " pwm_out"}, int'(pwm_out),
            int'(m_run != 0 && m_cnt < m_shadow * divof(presc_sel)));
      check({phase, " period_end"}, int'(period_end),
            int'(m_run != 0 && m_cnt == plen() - 1));
      check({phase, " duty_active"}, int'(duty_active), m_shadow);
    end
    if (cycles > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int p, input int s);
    en = 1'b0; clocks(2);
    period = 8'(p); presc_sel = 2'(s); clocks(2);
  endtask

  task automatic wr(input int d);
    duty_hi = 8'(d >> 2); duty_lo = 2'(d); duty_hi_we = 1'b1; duty_lo_we = 1'b1;
    clocks(1);
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
  endtask

  task automatic wait_pe();
    while (!period_end) clocks(1);
    clocks(1);
  endtask

  task automatic measure(input string tag, input int exp_len, input int exp_hi);
    int len = 0, hi = 0;
    wait_pe();
    do begin
      len++;
      if (pwm_out) hi++;
      clocks(1);
    end while (!period_end && len < 20000);
    if (period_end) begin len++; if (pwm_out) hi++; end
    check({tag, " period length"}, len, exp_len);
    check({tag, " high clocks"}, hi, exp_hi);
  endtask

  initial begin
    clocks(3);
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 period_end", int'(period_end), 0);
    check("R1 duty_active", int'(duty_active), 0);
    rst = 1'b0; clocks(1);

    phase = "R10"; en = 1'b1; clocks(50);
    check("R10 output low after reset", int'(pwm_out), 0);

    phase = "R5"; cfg(9, 0); wr(17); en = 1'b1;
    measure("R4 R6 div1", 40, 17);
    cfg(9, 1); en = 1'b1; measure("R5 div4", 160, 68);
    cfg(9, 2); en = 1'b1; measure("R5 div16 sel2", 640, 272);
    cfg(9, 3); en = 1'b1; measure("R5 div16 sel3", 640, 272);

    phase = "R7"; cfg(9, 0); wr(0); en = 1'b1; measure("R7 duty zero", 40, 0);
    phase = "R8"; cfg(9, 0); wr(50); en = 1'b1; measure("R8 duty above period", 40, 40);
    wr(40); wait_pe(); measure("R8 duty at period", 40, 40);
    wr(39); wait_pe(); measure("R6 duty one below", 40, 39);

    phase = "R3"; cfg(20, 1); wr(30); en = 1'b1;
    wait_pe(); clocks(10); wr(60); clocks(2);
    check("R3 duty held mid-period", int'(duty_active), 30);
    wait_pe();
    check("R3 duty taken at boundary", int'(duty_active), 60);

    phase = "R2"; duty_hi = 8'd5; duty_hi_we = 1'b1; clocks(1); duty_hi_we = 1'b0;
    wait_pe();
    check("R2 hi write keeps lo", int'(duty_active), (5 << 2) | 0);
    duty_lo = 2'd3; duty_lo_we = 1'b1; clocks(1); duty_lo_we = 1'b0;
    wait_pe();
    check("R2 lo write keeps hi", int'(duty_active), (5 << 2) | 3);

    phase = "R9"; clocks(7); en = 1'b0; clocks(1);
    check("R9 disabled output low", int'(pwm_out), 0);
    clocks(30);
    check("R9 no period_end while disabled", int'(period_end), 0);
    en = 1'b1; clocks(1);
    check("R9 restart high", int'(pwm_out), 1);
    clocks(300);

    phase = "R10"; rst = 1'b1; clocks(2); rst = 1'b0; clocks(100);
    check("R10 cleared buffer", int'(duty_active), 0);
    check("R10 low output", int'(pwm_out), 0);

    phase = "R6"; cfg(255, 2); wr(1000); en = 1'b1;
    measure("R6 full range", 16384, 16000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule